// File: doc/BRIEF.md
# Warm Reset Handshake Sequencer

This block is a reset controller with a single 32-bit control register. When software starts a warm reset, the block does not assert its warm reset output at once. It first works through a fixed list of peripheral agents. These are an SDRAM self-refresh agent, a bitstream-manager clock idler, a scan-chain clock idler, a programmable-fabric agent and a trace-master stall agent. Each agent that is enabled and not already in warm reset gets a request, and the block waits for that agent's acknowledge before it moves to the next one. Every wait has a programmable cycle limit, so an agent that never answers cannot block the reset.

Software can also drive each agent's request line by hand and read the acknowledge lines back through the register. Two one-shot trigger bits start a warm or a cold reset. A cold reset overrides any warm sequence in progress and returns the register to its power-up values.

The trace-master stall agent is special. If it is enabled when the warm reset is asserted, its stall request stays latched after the reset ends. It is released only when software writes 1 to a pending bit. Agent index i runs 0 to 4 in the order SDRAM, bitstream manager, scan manager, fabric, trace stall. For agent i, the enable sits at register bit 4+4i, the software request at 5+4i and the acknowledge at 6+4i. The trace-stall pending bit is bit 23.

Top module: `warmRstSeq`

## Requirements
- R1: After power-on reset the register reads 0x00100000. The only bit set is the trace-stall enable at bit 20. The warm and cold outputs are 0 and no agent request is driven.
- R2: Trigger bits 0 and 1 always read as 0. Reserved bits 2, 3, 7, 11, 15 and 19, and bits 24 to 31, always read as 0.
- R3: A register write loads each enable bit (4+4i) and software request bit (5+4i) from the write data. Software request bit i drives agentReq[i] directly. Bit 6+4i reads back agentAck[i] combinationally.
- R4: Writing 1 to bit 1 starts a warm sequence. Agents are visited in ascending index order. An enabled agent's request rises only after every earlier enabled agent has acknowledged or timed out. warmRstOut stays 0 until every visited agent has finished.
- R5: An agent whose enable bit is 0, or whose agentInRst input is 1, is skipped. It receives no request during the sequence, and each skip takes one cycle.
- R6: An enabled agent that never acknowledges keeps its request for cfgTimeout+1 cycles of waiting, and then the sequencer moves on. The request rises one cycle after the trigger edge when agent 0 is skipped. When agent 1 is the only enabled agent, warmRstOut rises cfgTimeout+1+3 cycles after agent 1's request rises.
- R7: warmRstOut stays high for exactly HOLD_CYCLES cycles. Requests issued by the sequencer stay asserted until that release. In the cycle warmRstOut falls, agents 0 to 3 are requested only through their software request bits.
- R8: If trace-stall enable (bit 20) is 1 when warmRstOut is asserted, pending bit 23 reads 1. agentReq[4] then stays high until software writes 1 to bit 23, which clears the bit and drops the request.
- R9: Writing 1 to bit 0 asserts coldRstOut in the next cycle for exactly HOLD_CYCLES cycles. The write aborts any warm sequence, with no later warm assertion. It drops every request and returns the register to 0x00100000. A write with bits 0 and 1 both set counts as a cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational) |
| cfgTimeout | input | TIMER_W | Handshake wait limit in cycles, minus one |
| agentAck | input | NUM_AGENTS | Acknowledge from each agent |
| agentInRst | input | NUM_AGENTS | Agent is already in warm reset |
| agentReq | output | NUM_AGENTS | Request to each agent |
| warmRstOut | output | 1 | Warm reset output |
| coldRstOut | output | 1 | Cold reset output |

## Verification
The hardest state to reach from the ports is a cold reset that lands in the middle of a handshake wait. The bench enables one agent that never answers and sets a long timeout, so the sequencer sits in the wait. It then writes both trigger bits together. After that it watches for several hundred cycles to prove that the abandoned warm reset never appears. The ordering checks use a responder that echoes requests back as acknowledges one cycle later. The bench watches for each request's first rise and checks that the rises arrive one at a time, in ascending order, and before any warm assertion.

// File: rtl/warmRstPkg.sv
package warmRstPkg;

  typedef struct packed {
    logic setPending;
    logic clearAll;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HS,
    ST_WARM,
    ST_COLD
  } seqState_t;

endpackage

// File: rtl/warmRstRegs.sv
module warmRstRegs
  import warmRstPkg::*;
#(
  parameter int NA = 5,
  parameter logic [NA-1:0] EN_RESET = {1'b1, {(NA-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [31:0]   wrData,
  input  seqStrobe_t    strobe,
  input  logic [NA-1:0] agentAck,
  output logic [31:0]   rdData,
  output logic [NA-1:0] enable,
  output logic [NA-1:0] swReq,
  output logic          pending,
  output logic          warmTrig,
  output logic          coldTrig
);

  localparam int FIELD_BASE   = 4;
  localparam int FIELD_STRIDE = 4;
  localparam int PEND_BIT     = FIELD_BASE + NA * FIELD_STRIDE - 1;

  assign warmTrig = wrEn & wrData[1];
  assign coldTrig = wrEn & wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= EN_RESET;
      swReq   <= '0;
      pending <= 1'b0;
    end else if (strobe.clearAll) begin
      enable  <= EN_RESET;
      swReq   <= '0;
      pending <= 1'b0;
    end else begin
      if (wrEn) begin
        for (int i = 0; i < NA; i++) begin
          enable[i] <= wrData[FIELD_BASE + i * FIELD_STRIDE];
          swReq[i]  <= wrData[FIELD_BASE + i * FIELD_STRIDE + 1];
        end
      end
      if (strobe.setPending)
        pending <= 1'b1;
      else if (wrEn && wrData[PEND_BIT])
        pending <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NA; i++) begin
      rdData[FIELD_BASE + i * FIELD_STRIDE]     = enable[i];
      rdData[FIELD_BASE + i * FIELD_STRIDE + 1] = swReq[i];
      rdData[FIELD_BASE + i * FIELD_STRIDE + 2] = agentAck[i];
    end
    rdData[PEND_BIT] = pending;
  end

endmodule

// File: rtl/warmRstCtrl.sv
module warmRstCtrl
  import warmRstPkg::*;
#(
  parameter int NA   = 5,
  parameter int TW   = 8,
  parameter int HOLD = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          warmTrig,
  input  logic          coldTrig,
  input  logic [NA-1:0] enable,
  input  logic [NA-1:0] agentInRst,
  input  logic [NA-1:0] agentAck,
  input  logic [TW-1:0] cfgTimeout,
  output seqStrobe_t    strobe,
  output logic [NA-1:0] hwReq,
  output logic          warmRstOut,
  output logic          coldRstOut
);

  localparam int IW = (NA > 1) ? $clog2(NA) : 1;
  localparam int CW = $clog2(HOLD + 1);

  seqState_t     state;
  logic [IW-1:0] idx;
  logic [TW-1:0] timer;
  logic [CW-1:0] holdCnt;
  logic [NA-1:0] held;

  logic skip, active, done, advance, lastIdx;

  assign skip    = !enable[idx] || agentInRst[idx];
  assign active  = (state == ST_HS) && !skip;
  assign done    = agentAck[idx] || (timer == cfgTimeout);
  assign advance = skip || done;
  assign lastIdx = (32'(idx) == NA - 1);

  assign strobe.clearAll   = coldTrig;
  assign strobe.setPending = (state == ST_HS) && advance && lastIdx && enable[NA-1];

  assign hwReq      = held | (active ? (NA'(1) << idx) : '0);
  assign warmRstOut = (state == ST_WARM);
  assign coldRstOut = (state == ST_COLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      timer   <= '0;
      holdCnt <= '0;
      held    <= '0;
    end else if (coldTrig) begin
      state   <= ST_COLD;
      idx     <= '0;
      timer   <= '0;
      holdCnt <= '0;
      held    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (warmTrig) begin
            state <= ST_HS;
            idx   <= '0;
            timer <= '0;
          end
        end
        ST_HS: begin
          if (advance) begin
            timer <= '0;
            if (active) held[idx] <= 1'b1;
            if (lastIdx) begin
              state   <= ST_WARM;
              holdCnt <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: begin
          if (holdCnt == CW'(HOLD - 1)) begin
            state <= ST_IDLE;
            held  <= '0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/warmRstSeq.sv
module warmRstSeq
  import warmRstPkg::*;
#(
  parameter int NUM_AGENTS  = 5,
  parameter int TIMER_W     = 8,
  parameter int HOLD_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  input  logic [TIMER_W-1:0]    cfgTimeout,
  input  logic [NUM_AGENTS-1:0] agentAck,
  input  logic [NUM_AGENTS-1:0] agentInRst,
  output logic [NUM_AGENTS-1:0] agentReq,
  output logic                  warmRstOut,
  output logic                  coldRstOut
);

  seqStrobe_t            strobe;
  logic [NUM_AGENTS-1:0] enable;
  logic [NUM_AGENTS-1:0] swReq;
  logic [NUM_AGENTS-1:0] hwReq;
  logic                  pending;
  logic                  warmTrig;
  logic                  coldTrig;

  warmRstRegs #(.NA(NUM_AGENTS)) regs (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .strobe   (strobe),
    .agentAck (agentAck),
    .rdData   (rdData),
    .enable   (enable),
    .swReq    (swReq),
    .pending  (pending),
    .warmTrig (warmTrig),
    .coldTrig (coldTrig)
  );

  warmRstCtrl #(.NA(NUM_AGENTS), .TW(TIMER_W), .HOLD(HOLD_CYCLES)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .warmTrig   (warmTrig),
    .coldTrig   (coldTrig),
    .enable     (enable),
    .agentInRst (agentInRst),
    .agentAck   (agentAck),
    .cfgTimeout (cfgTimeout),
    .strobe     (strobe),
    .hwReq      (hwReq),
    .warmRstOut (warmRstOut),
    .coldRstOut (coldRstOut)
  );

  assign agentReq = swReq | hwReq | {pending, {(NUM_AGENTS-1){1'b0}}};

endmodule

// File: rtl/warmRstSeqChk.sv
module warmRstSeqChk #(
  parameter int NA = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [31:0]   wrData,
  input logic [31:0]   rdData,
  input logic [NA-1:0] agentReq,
  input logic          warmRstOut,
  input logic          coldRstOut
);

  localparam int PEND_BIT = 4 + NA * 4 - 1;

  function automatic logic [31:0] usedBits();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NA; i++) begin
      m[4 + 4 * i]     = 1'b1;
      m[4 + 4 * i + 1] = 1'b1;
      m[4 + 4 * i + 2] = 1'b1;
    end
    m[PEND_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] USED = usedBits();

  logic [NA-2:0] swReqRd;
  always_comb begin
    for (int i = 0; i < NA - 1; i++) swReqRd[i] = rdData[4 + 4 * i + 1];
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~USED) == 32'h0);

  p_rst_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(warmRstOut && coldRstOut));

  p_cold_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0]) |=> (coldRstOut && !warmRstOut));

  p_release_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(warmRstOut) |-> ((agentReq[NA-2:0] & ~swReqRd) == '0));

  p_pend_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[PEND_BIT]) |-> warmRstOut);

  p_pend_holds_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[PEND_BIT] |-> agentReq[NA-1]);

endmodule

bind warmRstSeq warmRstSeqChk #(.NA(NUM_AGENTS)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .agentReq   (agentReq),
  .warmRstOut (warmRstOut),
  .coldRstOut (coldRstOut)
);

// File: tb/warmRstSeq_test.sv
module warmRstSeq_test;

  localparam int NA   = 5;
  localparam int TW   = 8;
  localparam int HOLD = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [TW-1:0] cfgTimeout = 8'd50;
  logic [NA-1:0] agentAck;
  logic [NA-1:0] agentInRst = '0;
  logic [NA-1:0] agentReq;
  logic          warmRstOut;
  logic          coldRstOut;

  logic [NA-1:0] respAck = '0;
  logic [NA-1:0] ackMask = '0;
  logic [NA-1:0] ackForce = '0;
  assign agentAck = respAck | ackForce;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) respAck <= agentReq & ackMask;

  warmRstSeq #(.NUM_AGENTS(NA), .TIMER_W(TW), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cfgTimeout(cfgTimeout), .agentAck(agentAck), .agentInRst(agentInRst),
    .agentReq(agentReq), .warmRstOut(warmRstOut), .coldRstOut(coldRstOut)
  );

  typedef struct packed {
    logic [31:0]   wr;
    logic [31:0]   rd;
    logic [NA-1:0] req;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 32'h0000_0000, 5'b00000},
    '{32'hFFFF_FFFC, 32'h0033_3330, 5'b11111},
    '{32'h0000_0020, 32'h0000_0020, 5'b00001},
    '{32'h0002_2200, 32'h0002_2200, 5'b01110},
    '{32'h0020_008C, 32'h0020_0000, 5'b10000},
    '{32'h0011_0110, 32'h0011_0110, 5'b00000}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic runWarm(input logic [31:0] trigWord, input logic [NA-1:0] expSeen);
    logic [NA-1:0] seen, newBits;
    int lastIdx, warmCnt;
    logic orderOk, preWarmOk, warmSeen;
    seen = '0; lastIdx = -1; warmCnt = 0; orderOk = 1'b1; preWarmOk = 1'b1; warmSeen = 1'b0;
    regWrite(trigWord);
    check(rdData[1:0] == 2'b00, "R2 trigger bits read zero", {30'b0, rdData[1:0]}, 0);
    for (int c = 0; c < 3000; c++) begin
      newBits = agentReq & ~seen;
      if (newBits != '0) begin
        if ($countones(newBits) != 1) orderOk = 1'b0;
        for (int i = 0; i < NA; i++)
          if (newBits[i]) begin
            if (i <= lastIdx) orderOk = 1'b0;
            lastIdx = i;
          end
        if (warmRstOut) preWarmOk = 1'b0;
        seen = seen | newBits;
      end
      if (warmRstOut) begin
        warmSeen = 1'b1;
        warmCnt++;
      end else if (warmSeen) begin
        break;
      end
      @(negedge clk);
    end
    check(orderOk, "R4 requests rise one at a time in ascending order", {27'b0, seen}, {27'b0, expSeen});
    check(preWarmOk, "R4 no request first rises after warm assertion", 0, 1);
    check(seen == expSeen, "R5 set of agents requested", {27'b0, seen}, {27'b0, expSeen});
    check(warmCnt == HOLD, "R7 warm reset hold length", warmCnt, HOLD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic sawWarm;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdData == 32'h0010_0000, "R1 reset register value", rdData, 32'h0010_0000);
    check(!warmRstOut && !coldRstOut, "R1 reset outputs low", {30'b0, warmRstOut, coldRstOut}, 0);
    check(agentReq == '0, "R1 no request after reset", {27'b0, agentReq}, 0);

    // R3 / R2 register vector table
    foreach (VECS[k]) begin
      regWrite(VECS[k].wr);
      check(rdData == VECS[k].rd, "R3 readback of written fields (R2 reserved zero)", rdData, VECS[k].rd);
      check(agentReq == VECS[k].req, "R3 software requests drive agentReq", {27'b0, agentReq}, {27'b0, VECS[k].req});
    end
    regWrite(32'h0010_0000);

    // R3 acknowledge reflection
    ackForce = 5'b10101;
    #1;
    check(rdData == 32'h0050_4040, "R3 ack bits 6,14,22", rdData, 32'h0050_4040);
    ackForce = 5'b01010;
    #1;
    check(rdData == 32'h0014_0400, "R3 ack bits 10,18", rdData, 32'h0014_0400);
    ackForce = '0;
    @(negedge clk);

    // R4 R7 R8 full sequence with responding agents
    ackMask = 5'b11111;
    cfgTimeout = 8'd50;
    runWarm(32'h0011_1112, 5'b11111);
    check(rdData[23] == 1'b1, "R8 pending set after warm reset", {31'b0, rdData[23]}, 1);
    check(agentReq == 5'b10000, "R7 R8 only trace stall held after release", {27'b0, agentReq}, 32'h10);
    repeat (20) @(negedge clk);
    check(agentReq == 5'b10000, "R8 trace stall still latched", {27'b0, agentReq}, 32'h10);
    regWrite(32'h0090_0000);
    check(rdData == 32'h0010_0000 || rdData == 32'h0050_0000, "R8 pending cleared by write one",
          rdData & 32'hFFBF_FFFF, 32'h0010_0000);
    check(agentReq == '0, "R8 trace stall released", {27'b0, agentReq}, 0);
    repeat (3) @(negedge clk);

    // R5 skip disabled and in-reset agents
    agentInRst = 5'b00100;
    runWarm(32'h0000_1012, 5'b00001);
    check(rdData[23] == 1'b0, "R5 R8 no pending when trace disabled", {31'b0, rdData[23]}, 0);
    check(agentReq == '0, "R7 all hardware requests dropped", {27'b0, agentReq}, 0);
    agentInRst = '0;
    repeat (3) @(negedge clk);

    // R6 timeout on a silent agent
    ackMask = '0;
    cfgTimeout = 8'd5;
    regWrite(32'h0000_0102);
    cnt = 0;
    sawWarm = 1'b0;
    for (int c = 0; c < 500; c++) begin
      if (warmRstOut) begin
        sawWarm = 1'b1;
        break;
      end
      if (agentReq[1]) cnt++;
      @(negedge clk);
    end
    check(sawWarm, "R6 warm reset reached despite no acknowledge", {31'b0, sawWarm}, 1);
    check(cnt == 5 + 1 + 3, "R6 request cycles before warm", cnt, 9);
    repeat (HOLD + 4) @(negedge clk);
    check(agentReq == '0, "R7 timed-out request dropped after release", {27'b0, agentReq}, 0);

    // R9 cold reset aborts a waiting warm sequence
    cfgTimeout = 8'd200;
    regWrite(32'h0000_0102);
    repeat (10) @(negedge clk);
    check(agentReq[1] && !warmRstOut, "R9 sequence waiting on agent 1", {27'b0, agentReq}, 32'h2);
    regWrite(32'h0000_0003);
    check(coldRstOut && !warmRstOut, "R9 cold output next cycle, cold wins", {30'b0, coldRstOut, warmRstOut}, 2);
    check(agentReq == '0, "R9 requests dropped on cold", {27'b0, agentReq}, 0);
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      if (coldRstOut) cnt++;
      @(negedge clk);
    end
    check(cnt == HOLD, "R9 cold hold length", cnt, HOLD);
    check(rdData == 32'h0010_0000, "R9 register back to reset value", rdData, 32'h0010_0000);
    sawWarm = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (warmRstOut || agentReq != '0) sawWarm = 1'b1;
      @(negedge clk);
    end
    check(!sawWarm, "R9 aborted warm reset never asserted", {31'b0, sawWarm}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule